// File: doc/BRIEF.md
# Clock-Domain-Confirmed Global Control Register

This block holds the global control word of a serial port whose receive and transmit engines each run on a slow bit clock of their own. The bus clock is much faster than either bit clock. A bus master writes the 32-bit word through a small valid/address/data port. It can write the whole word at the main address, or change one half through one of two alias addresses. The receive half is bits 15:0 and the transmit half is bits 31:16. Each half goes into its bit-clock domain through a toggle handshake with a two-flop synchronizer. The value that domain latched then comes back to the bus domain through a second two-flop synchronizer.

The two kinds of readback behave differently. A read at the main address returns, for each half, only the value its bit-clock domain has confirmed. Software polls this address until the word it wrote appears. A read at either alias returns the raw written word at once, which helps when debugging. If a bit clock stops, that half's confirmation stays pending and the other half is not affected. In synchronous mode the receive half is also confirmed through the transmit bit clock, so it still completes while the receive clock is idle.

Top module: `gctl_cdc_reg`

## Requirements
- R1: After reset, reads at every address return zero and all three slow-side outputs are zero.
- R2: A write at address 0 (main) updates both halves. An alias read in the following cycles returns the full written word.
- R3: A write at address 1 (receive alias) changes only bits 15:0 of the raw word. Bits 31:16 keep their value.
- R4: A write at address 2 (transmit alias) changes only bits 31:16 of the raw word. Bits 15:0 keep their value.
- R5: A read at address 1 or 2 returns the raw word on `bus_rdata` one bus cycle later, including the value written in the cycle just before.
- R6: A read at address 0 returns {transmit confirmed, receive confirmed}. Right after a write, it still shows the previous confirmed value.
- R7: A written half appears at address 0 within five periods of its bit clock plus eight bus cycles, and its slow-side output carries the same value.
- R8: While one bit clock is stopped, that half's confirmed value and slow output keep their old value. The other half still confirms. The stopped half completes once its clock restarts.
- R9: Writes to a half while its transfer is in flight are held. Only the last one is forwarded after the acknowledge returns. The final confirmed value and slow output equal the last write, and the in-flight data stays stable.
- R10: With `sync_mode` high (changed only while idle, with both clocks running), the receive half is confirmed through `tx_bclk` and appears on `rx_ctl_sync_o`, even while `rx_bclk` is stopped.
- R11: Address 3 is unmapped. Writes there change nothing, and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 main, 1 receive alias, 2 transmit alias, 3 unmapped |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one cycle after a read |
| sync_mode | input | 1 | 1 = receive half confirmed through transmit bit clock |
| rx_bclk | input | 1 | Receive bit clock |
| rx_rst | input | 1 | Synchronous active-high reset, receive domain |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_rst | input | 1 | Synchronous active-high reset, transmit domain |
| rx_ctl_o | output | 16 | Receive half as latched in the receive domain |
| rx_ctl_sync_o | output | 16 | Receive half as latched in the transmit domain |
| tx_ctl_o | output | 16 | Transmit half as latched in the transmit domain |

## Verification
The critical coincidence is a new write to a half in the same bus cycle that the acknowledge of its previous transfer completes. In that cycle the held write is launched and the new write must take the pending slot. The bench provokes this with bursts of back-to-back alias writes to one half, mixed with random writes, while the bit clocks run at unrelated periods. It judges the result by polling address 0 until the last written value shows and by comparing the slow-side output with it. Assertions check that in-flight data never moves and that a request toggles only when the half is idle.

// File: rtl/gctl_pkg.sv
package gctl_pkg;
  typedef enum logic [1:0] {
    A_MAIN  = 2'd0,
    A_RXALS = 2'd1,
    A_TXALS = 2'd2,
    A_NONE  = 2'd3
  } gctl_addr_e;
endpackage

// File: rtl/gctl_src.sv
// Bus-side launcher for one half: toggle request, held data, pending slot,
// acknowledge and confirmed-value return synchronizers.
module gctl_src #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         ack_async,
  input  logic [W-1:0] q_async,
  output logic         req_tgl,
  output logic [W-1:0] hold,
  output logic         busy,
  output logic [W-1:0] conf
);
  logic         ack_s1, ack_s2, ack_s3;
  logic [W-1:0] q_s1, q_s2;
  logic [W-1:0] pend;
  logic         pend_v;

  assign busy = (req_tgl != ack_s3);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_s1  <= 1'b0;
      ack_s2  <= 1'b0;
      ack_s3  <= 1'b0;
      q_s1    <= '0;
      q_s2    <= '0;
      conf    <= '0;
      req_tgl <= 1'b0;
      hold    <= '0;
      pend    <= '0;
      pend_v  <= 1'b0;
    end else begin
      ack_s1 <= ack_async;
      ack_s2 <= ack_s1;
      ack_s3 <= ack_s2;
      q_s1   <= q_async;
      q_s2   <= q_s1;
      if (ack_s2 != ack_s3) conf <= q_s2;
      if (!busy) begin
        if (pend_v) begin
          hold    <= pend;
          req_tgl <= ~req_tgl;
          pend_v  <= wr_en;
          if (wr_en) pend <= wr_data;
        end else if (wr_en) begin
          hold    <= wr_data;
          req_tgl <= ~req_tgl;
        end
      end else if (wr_en) begin
        pend   <= wr_data;
        pend_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/gctl_dst.sv
// Slow-side receiver: detects a request toggle, latches held data, echoes ack.
module gctl_dst #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_async,
  input  logic [W-1:0] data_async,
  output logic [W-1:0] q,
  output logic         ack
);
  logic r_s1, r_s2, r_s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_s1 <= 1'b0;
      r_s2 <= 1'b0;
      r_s3 <= 1'b0;
      q    <= '0;
      ack  <= 1'b0;
    end else begin
      r_s1 <= req_async;
      r_s2 <= r_s1;
      r_s3 <= r_s2;
      if (r_s2 != r_s3) begin
        q   <= data_async;
        ack <= r_s2;
      end
    end
  end
endmodule

// File: rtl/gctl_cdc_reg.sv
module gctl_cdc_reg #(
  parameter int HALF_W = 16
) (
  input  logic                  bus_clk,
  input  logic                  bus_rst,
  input  logic                  bus_valid,
  input  logic                  bus_write,
  input  logic [1:0]            bus_addr,
  input  logic [2*HALF_W-1:0]   bus_wdata,
  output logic [2*HALF_W-1:0]   bus_rdata,
  input  logic                  sync_mode,
  input  logic                  rx_bclk,
  input  logic                  rx_rst,
  input  logic                  tx_bclk,
  input  logic                  tx_rst,
  output logic [HALF_W-1:0]     rx_ctl_o,
  output logic [HALF_W-1:0]     rx_ctl_sync_o,
  output logic [HALF_W-1:0]     tx_ctl_o
);
  import gctl_pkg::*;
  localparam int REG_W = 2 * HALF_W;

  logic [REG_W-1:0]  shadow;
  logic              rx_wr, tx_wr;
  logic              rx_req, tx_req, rx_busy, tx_busy;
  logic [HALF_W-1:0] rx_hold, tx_hold, rx_conf, tx_conf;
  logic              ack_rx_r, ack_rx_t, ack_tx;
  logic              rx_ack_sel;
  logic [HALF_W-1:0] rx_q_sel;
  gctl_addr_e        a;

  assign a     = gctl_addr_e'(bus_addr);
  assign rx_wr = bus_valid && bus_write && (a == A_MAIN || a == A_RXALS);
  assign tx_wr = bus_valid && bus_write && (a == A_MAIN || a == A_TXALS);

  always_ff @(posedge bus_clk) begin
    if (bus_rst) begin
      shadow    <= '0;
      bus_rdata <= '0;
    end else begin
      if (rx_wr) shadow[HALF_W-1:0]     <= bus_wdata[HALF_W-1:0];
      if (tx_wr) shadow[REG_W-1:HALF_W] <= bus_wdata[REG_W-1:HALF_W];
      if (bus_valid && !bus_write) begin
        case (a)
          A_MAIN:          bus_rdata <= {tx_conf, rx_conf};
          A_RXALS, A_TXALS: bus_rdata <= shadow;
          default:         bus_rdata <= '0;
        endcase
      end
    end
  end

  assign rx_ack_sel = sync_mode ? ack_rx_t : ack_rx_r;
  assign rx_q_sel   = sync_mode ? rx_ctl_sync_o : rx_ctl_o;

  gctl_src #(.W(HALF_W)) u_rx_src (
    .clk(bus_clk), .rst(bus_rst), .wr_en(rx_wr),
    .wr_data(bus_wdata[HALF_W-1:0]), .ack_async(rx_ack_sel),
    .q_async(rx_q_sel), .req_tgl(rx_req), .hold(rx_hold),
    .busy(rx_busy), .conf(rx_conf)
  );

  gctl_src #(.W(HALF_W)) u_tx_src (
    .clk(bus_clk), .rst(bus_rst), .wr_en(tx_wr),
    .wr_data(bus_wdata[REG_W-1:HALF_W]), .ack_async(ack_tx),
    .q_async(tx_ctl_o), .req_tgl(tx_req), .hold(tx_hold),
    .busy(tx_busy), .conf(tx_conf)
  );

  gctl_dst #(.W(HALF_W)) u_rx_dst (
    .clk(rx_bclk), .rst(rx_rst), .req_async(rx_req),
    .data_async(rx_hold), .q(rx_ctl_o), .ack(ack_rx_r)
  );

  gctl_dst #(.W(HALF_W)) u_rx_dst_tx (
    .clk(tx_bclk), .rst(tx_rst), .req_async(rx_req),
    .data_async(rx_hold), .q(rx_ctl_sync_o), .ack(ack_rx_t)
  );

  gctl_dst #(.W(HALF_W)) u_tx_dst (
    .clk(tx_bclk), .rst(tx_rst), .req_async(tx_req),
    .data_async(tx_hold), .q(tx_ctl_o), .ack(ack_tx)
  );
endmodule

// File: rtl/gctl_cdc_chk.sv
module gctl_cdc_chk #(
  parameter int HALF_W = 16
) (
  input logic                  bus_clk,
  input logic                  bus_rst,
  input logic                  bus_valid,
  input logic                  bus_write,
  input logic [1:0]            bus_addr,
  input logic [2*HALF_W-1:0]   bus_wdata,
  input logic [2*HALF_W-1:0]   bus_rdata,
  input logic [2*HALF_W-1:0]   shadow,
  input logic                  rx_busy,
  input logic                  tx_busy,
  input logic                  rx_req,
  input logic                  tx_req,
  input logic [HALF_W-1:0]     rx_hold,
  input logic [HALF_W-1:0]     tx_hold,
  input logic [HALF_W-1:0]     rx_conf,
  input logic [HALF_W-1:0]     tx_conf
);
  localparam int REG_W = 2 * HALF_W;

  // R3
  rx_alias_keeps_tx_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (bus_valid && bus_write && bus_addr == 2'd1) |=> $stable(shadow[REG_W-1:HALF_W]));
  // R4
  tx_alias_keeps_rx_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (bus_valid && bus_write && bus_addr == 2'd2) |=> $stable(shadow[HALF_W-1:0]));
  // R5
  alias_fresh_rd_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (bus_valid && bus_write && bus_addr == 2'd1 ##1 bus_valid && !bus_write && bus_addr == 2'd1)
    |=> bus_rdata[HALF_W-1:0] == $past(bus_wdata[HALF_W-1:0], 2));
  // R9
  rx_hold_stable_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (rx_busy && $past(rx_busy)) |-> $stable(rx_hold));
  // R9
  tx_hold_stable_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (tx_busy && $past(tx_busy)) |-> $stable(tx_hold));
  // R9
  rx_req_idle_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (rx_req != $past(rx_req)) |-> !$past(rx_busy));
  // R9
  tx_req_idle_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (tx_req != $past(tx_req)) |-> !$past(tx_busy));
  // R6
  rx_conf_on_ack_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (rx_conf != $past(rx_conf)) |-> $past(rx_busy));
  // R6
  tx_conf_on_ack_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (tx_conf != $past(tx_conf)) |-> $past(tx_busy));
  // R11
  unmapped_rd_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (bus_valid && !bus_write && bus_addr == 2'd3) |=> bus_rdata == '0);
endmodule

bind gctl_cdc_reg gctl_cdc_chk #(.HALF_W(HALF_W)) u_chk (
  .bus_clk(bus_clk), .bus_rst(bus_rst), .bus_valid(bus_valid),
  .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .shadow(shadow), .rx_busy(rx_busy),
  .tx_busy(tx_busy), .rx_req(rx_req), .tx_req(tx_req),
  .rx_hold(rx_hold), .tx_hold(tx_hold), .rx_conf(rx_conf),
  .tx_conf(tx_conf)
);

// File: tb/gctl_cdc_reg_tb.sv
module gctl_cdc_reg_tb;
  localparam int H = 16;
  localparam int RXP = 170;
  localparam int TXP = 230;
  localparam int RX_LIM = (5 * RXP) / 10 + 8;
  localparam int TX_LIM = (5 * TXP) / 10 + 8;

  logic          clk = 1'b0, rst = 1'b1;
  logic          valid = 1'b0, write = 1'b0;
  logic [1:0]    addr = '0;
  logic [2*H-1:0] wdata = '0;
  logic [2*H-1:0] rdata;
  logic          sync_mode = 1'b0;
  logic          rx_bclk = 1'b0, tx_bclk = 1'b0;
  logic          rx_run = 1'b1, tx_run = 1'b1;
  logic [H-1:0]  rx_ctl, rx_ctl_sync, tx_ctl;
  int            total = 0, bad = 0;
  logic [2*H-1:0] raw = '0;

  always #5 clk = ~clk;
  always begin #(RXP/2); if (rx_run) rx_bclk = ~rx_bclk; end
  always begin #(TXP/2); if (tx_run) tx_bclk = ~tx_bclk; end

  gctl_cdc_reg #(.HALF_W(H)) u_dut (
    .bus_clk(clk), .bus_rst(rst), .bus_valid(valid), .bus_write(write),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .sync_mode(sync_mode), .rx_bclk(rx_bclk), .rx_rst(rst),
    .tx_bclk(tx_bclk), .tx_rst(rst), .rx_ctl_o(rx_ctl),
    .rx_ctl_sync_o(rx_ctl_sync), .tx_ctl_o(tx_ctl)
  );

  function automatic logic [2*H-1:0] upd(input logic [2*H-1:0] r,
                                         input logic [1:0] a, input logic [2*H-1:0] d);
    case (a)
      2'd0: upd = d;
      2'd1: upd = {r[2*H-1:H], d[H-1:0]};
      2'd2: upd = {d[2*H-1:H], r[H-1:0]};
      default: upd = r;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [2*H-1:0] act, input logic [2*H-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [2*H-1:0] d);
    @(negedge clk); valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk); valid = 1'b0; write = 1'b0;
    raw = upd(raw, a, d);
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [2*H-1:0] d);
    @(negedge clk); valid = 1'b1; write = 1'b0; addr = a;
    @(negedge clk); valid = 1'b0;
    d = rdata;
  endtask

  task automatic poll_main(input logic [2*H-1:0] exp, input int lim,
                           input string tag, output int cyc);
    logic [2*H-1:0] d = '0;
    cyc = 0;
    for (int i = 0; i < lim; i++) begin
      bus_rd(2'd0, d);
      cyc = i + 1;
      if (d == exp) break;
    end
    chk(d == exp, tag, d, exp);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2*H-1:0] d, v, old;
    int cyc;
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    repeat (40) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      bus_rd(i[1:0], d);
      chk(d == '0, "R1 reset read", d, '0);
    end
    chk({rx_ctl, tx_ctl} == '0, "R1 slow outputs", {rx_ctl, tx_ctl}, '0);

    // R2 / R6 / R7 main write
    bus_wr(2'd0, 32'hA5A5_1234);
    bus_rd(2'd0, d);
    chk(d == '0, "R6 main shows old value", d, '0);
    bus_rd(2'd1, d);
    chk(d == 32'hA5A5_1234, "R2 alias shows full write", d, 32'hA5A5_1234);
    poll_main(32'hA5A5_1234, 400, "R7 main confirm", cyc);
    chk(cyc <= TX_LIM, "R7 latency bound", cyc, TX_LIM);
    chk(rx_ctl == 16'h1234, "R7 rx slow output", rx_ctl, 16'h1234);
    chk(tx_ctl == 16'hA5A5, "R7 tx slow output", tx_ctl, 16'hA5A5);

    // R3 / R4 / R5 alias behaviour
    bus_wr(2'd1, 32'hFFFF_0BEE);
    bus_rd(2'd1, d);
    chk(d == 32'hA5A5_0BEE, "R3 rx alias keeps tx half", d, 32'hA5A5_0BEE);
    poll_main(32'hA5A5_0BEE, 400, "R3 rx alias confirm", cyc);
    chk(cyc <= RX_LIM, "R7 rx latency bound", cyc, RX_LIM);
    bus_wr(2'd2, 32'h7777_FFFF);
    bus_rd(2'd2, d);
    chk(d == 32'h7777_0BEE, "R4 tx alias keeps rx half", d, 32'h7777_0BEE);
    bus_rd(2'd0, d);
    chk(d == 32'hA5A5_0BEE, "R6 main lags tx alias write", d, 32'hA5A5_0BEE);
    poll_main(32'h7777_0BEE, 400, "R4 tx alias confirm", cyc);

    // R11 unmapped address
    bus_wr(2'd3, 32'hDEAD_BEEF);
    bus_rd(2'd3, d);
    chk(d == '0, "R11 unmapped read", d, '0);
    bus_rd(2'd1, d);
    chk(d == 32'h7777_0BEE, "R11 unmapped write ignored", d, 32'h7777_0BEE);
    bus_rd(2'd0, d);
    chk(d == 32'h7777_0BEE, "R11 confirmed unchanged", d, 32'h7777_0BEE);

    // R9 back-to-back writes to one half
    bus_wr(2'd1, 32'h0000_1111);
    bus_wr(2'd1, 32'h0000_2222);
    bus_wr(2'd1, 32'h0000_3333);
    poll_main(32'h7777_3333, 600, "R9 last write confirmed", cyc);
    chk(rx_ctl == 16'h3333, "R9 rx slow output final", rx_ctl, 16'h3333);

    // R8 stopped receive clock
    rx_run = 1'b0;
    bus_wr(2'd0, 32'h4242_5555);
    poll_main(32'h4242_3333, 600, "R8 tx half confirms alone", cyc);
    repeat (300) @(negedge clk);
    bus_rd(2'd0, d);
    chk(d[H-1:0] == 16'h3333, "R8 stopped half holds", d, 32'h4242_3333);
    chk(rx_ctl == 16'h3333, "R8 stopped slow output holds", rx_ctl, 16'h3333);
    rx_run = 1'b1;
    poll_main(32'h4242_5555, 600, "R8 resumes after restart", cyc);

    // R10 synchronous mode
    sync_mode = 1'b1;
    repeat (10) @(negedge clk);
    rx_run = 1'b0;
    bus_wr(2'd1, 32'h0000_6A6A);
    poll_main(32'h4242_6A6A, 600, "R10 rx half via tx clock", cyc);
    chk(rx_ctl_sync == 16'h6A6A, "R10 sync copy", rx_ctl_sync, 16'h6A6A);
    rx_run = 1'b1;
    repeat (400) @(negedge clk);
    sync_mode = 1'b0;
    repeat (100) @(negedge clk);
    chk(rx_ctl == 16'h6A6A, "R10 rx domain caught up", rx_ctl, 16'h6A6A);

    // random mix of addresses and values
    for (int k = 0; k < 16; k++) begin
      logic [1:0] a;
      a = 2'($urandom_range(0, 2));
      v = $urandom;
      old = raw;
      bus_wr(a, v);
      bus_rd((a == 2'd2) ? 2'd2 : 2'd1, d);
      chk(d == upd(old, a, v), (a == 2'd0) ? "R2 random alias" :
          (a == 2'd1) ? "R3 random alias" : "R4 random alias", d, upd(old, a, v));
      if (k % 3 == 0) begin
        bus_wr(2'd1, v ^ 32'h0000_FFFF);
        bus_wr(2'd1, v ^ 32'h0000_00FF);
      end
      poll_main(raw, 600, "R9 random confirm", cyc);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule